// File: doc/BRIEF.md
# Fine-Grained Multithreaded Lane Pipeline

This block is the arithmetic back end for one group of processing lanes. Eight lanes share one issue port. A 32-thread warp enters as four beats on four valid clocks. On each beat every lane takes the operands of one thread and applies the beat's opcode. Each pipeline stage carries its own valid bit, warp tag and sub-cycle tag. Neighbouring stages can therefore hold different threads and even different warps.

Every operation takes the same number of stages. Results leave in the order they were issued, with one row per clock and no stalls. The block has no hazard check and no forwarding path. The upstream scheduler is trusted not to re-issue a warp before its earlier results have retired. A done strobe marks the row that completes a warp and reports that warp's tag.

Top module: `mt_lane_pipe`

## Requirements
- R1: A synchronous active-low reset empties every stage. After reset, `res_valid` and `done` are low, and the next issued beat is treated as sub-cycle 0 of a warp, even if reset arrived part way through a warp.
- R2: A beat sampled on a rising edge with `iss_valid` high shows `res_valid` high right after the 8th rising edge (DEPTH), counting the sampling edge as the first. This latency is the same for every opcode.
- R3: The block accepts one beat on every clock with no stall. Results come out back to back, in issue order, and `res_warp` reports the warp tag sampled with that beat.
- R4: Valid beats are counted modulo 4 from reset, and each beat's position in that count is its sub-cycle c. Lane k of a result reports thread index c*8+k in `res_tid`, using 5 bits per lane with lane 0 in bits [4:0].
- R5: Opcode 2'b00 passes operand a through unchanged. The unused code 2'b11 behaves the same way.
- R6: Opcode 2'b01 returns a+b modulo 2^16 for each lane. Lane k's operands sit in bits [16k+15:16k] of each operand bus.
- R7: Opcode 2'b10 returns a*b+c modulo 2^16 for each lane.
- R8: A clock with `iss_valid` low is a bubble. Its output cycle has `res_valid` and `done` low, and it does not advance the sub-cycle count.
- R9: `done` is high exactly in the cycles whose result row is sub-cycle 3. In those cycles `done_warp` equals that beat's warp tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | Issue beat present |
| iss_warp | input | 5 | Warp tag of the beat |
| iss_op | input | 2 | Opcode of the beat |
| iss_a | input | 128 | Operand a, 16 bits per lane |
| iss_b | input | 128 | Operand b, 16 bits per lane |
| iss_c | input | 128 | Operand c, 16 bits per lane |
| res_valid | output | 1 | Result row present |
| res_warp | output | 5 | Warp tag of the result row |
| res_tid | output | 40 | Thread index per lane, 5 bits each |
| res_data | output | 128 | Result per lane, 16 bits each |
| done | output | 1 | Last row of a warp leaves this cycle |
| done_warp | output | 5 | Warp tag that completed |

## Verification
Warps are first issued back to back, once with each opcode. This shows that latency does not depend on the operation and that several warps can be in flight together. A long random run then places bubbles between beats at random. It separates the valid bit travelling with each stage from a simple free-running count, and it tests that bubbles neither create results nor move the sub-cycle count. All-ones operands push add and multiply-add through wrap-around. A reset part way through a warp shows whether the sub-cycle count really restarts.

// File: rtl/lanepipe_pkg.sv
// Shared sizes and opcode encoding for the multithreaded lane pipeline.
package lanepipe_pkg;
    localparam int LANES = 8;   // physical lanes
    localparam int SUBS  = 4;   // beats per warp
    localparam int DEPTH = 8;   // pipeline stages
    localparam int DW    = 16;  // lane data width
    localparam int WARPW = 5;   // warp tag width

    typedef enum logic [1:0] {
        OPC_MOVE = 2'b00,
        OPC_ADD  = 2'b01,
        OPC_MAD  = 2'b10,
        OPC_RSVD = 2'b11
    } opc_e;
endpackage

// File: rtl/beat_counter.sv
// Sub-cycle counter: counts accepted beats modulo SUBS so that each beat
// knows its position within its warp. Assumes beats of one warp are issued
// in order; bubbles between them are allowed.
module beat_counter #(
    parameter int SUBS = 4,
    localparam int SUBW = (SUBS > 1) ? $clog2(SUBS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [SUBW-1:0] sub
);
    // advance on every accepted beat, wrap after the last sub-cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub <= '0;
        else if (adv)
            sub <= (sub == SUBW'(SUBS - 1)) ? '0 : sub + 1'b1;
    end
endmodule

// File: rtl/lane_alu.sv
// One lane's operation unit: pure combinational, so every opcode takes the
// same number of stages downstream. Results wrap modulo 2^DW.
module lane_alu
    import lanepipe_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [1:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] c,
    output logic [DW-1:0] y
);
    // select the operation; unused code falls back to pass-through
    always_comb begin
        case (opc_e'(op))
            OPC_ADD: y = a + b;
            OPC_MAD: y = a * b + c;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/stage_chain.sv
// Fixed-depth register chain with a valid bit per stage. No stall input:
// every stage advances every clock. Payload registers load only when the
// stage feeding them holds a valid entry. Assumes DEPTH >= 2.
module stage_chain #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_pl,
    output logic         out_vld,
    output logic [W-1:0] out_pl
);
    logic [DEPTH-1:0]        vld_q;
    logic [DEPTH-1:0][W-1:0] pl_q;

    // shift valid bits down the chain, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else
            vld_q <= {vld_q[DEPTH-2:0], in_vld};
    end

    // move payloads along, holding a stage when a bubble is behind it
    always_ff @(posedge clk) begin
        if (in_vld)
            pl_q[0] <= in_pl;
        for (int s = 1; s < DEPTH; s++) begin
            if (vld_q[s-1])
                pl_q[s] <= pl_q[s-1];
        end
    end

    assign out_vld = vld_q[DEPTH-1];
    assign out_pl  = pl_q[DEPTH-1];
endmodule

// File: rtl/mt_lane_pipe.sv
// Fine-grained multithreaded lane pipeline. Each accepted beat carries one
// thread per lane; its warp and sub-cycle tags travel with it, so every stage
// may belong to a different thread. Assumes the scheduler never issues work
// that depends on a result still in flight (no hazard logic here).
module mt_lane_pipe
    import lanepipe_pkg::*;
#(
    parameter int LANES = lanepipe_pkg::LANES,
    parameter int SUBS  = lanepipe_pkg::SUBS,
    parameter int DEPTH = lanepipe_pkg::DEPTH,
    parameter int DW    = lanepipe_pkg::DW,
    parameter int WARPW = lanepipe_pkg::WARPW,
    localparam int SUBW = (SUBS > 1) ? $clog2(SUBS) : 1,
    localparam int TIDW = $clog2(LANES * SUBS),
    localparam int ROWW = LANES * DW,
    localparam int PLW  = WARPW + SUBW + ROWW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_valid,
    input  logic [WARPW-1:0]      iss_warp,
    input  logic [1:0]            iss_op,
    input  logic [ROWW-1:0]       iss_a,
    input  logic [ROWW-1:0]       iss_b,
    input  logic [ROWW-1:0]       iss_c,
    output logic                  res_valid,
    output logic [WARPW-1:0]      res_warp,
    output logic [LANES*TIDW-1:0] res_tid,
    output logic [ROWW-1:0]       res_data,
    output logic                  done,
    output logic [WARPW-1:0]      done_warp
);
    logic [SUBW-1:0] iss_sub;
    logic [ROWW-1:0] alu_row;
    logic            out_vld;
    logic [PLW-1:0]  out_pl;
    logic [SUBW-1:0] out_sub;

    beat_counter #(.SUBS(SUBS)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (iss_valid),
        .sub   (iss_sub)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_alu #(.DW(DW)) u_alu (
            .op (iss_op),
            .a  (iss_a[k*DW +: DW]),
            .b  (iss_b[k*DW +: DW]),
            .c  (iss_c[k*DW +: DW]),
            .y  (alu_row[k*DW +: DW])
        );
    end

    stage_chain #(.DEPTH(DEPTH), .W(PLW)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (iss_valid),
        .in_pl   ({iss_warp, iss_sub, alu_row}),
        .out_vld (out_vld),
        .out_pl  (out_pl)
    );

    assign {res_warp, out_sub, res_data} = out_pl;
    assign res_valid = out_vld;
    assign done      = out_vld && (out_sub == SUBW'(SUBS - 1));
    assign done_warp = res_warp;

    for (genvar k = 0; k < LANES; k++) begin : g_tid
        assign res_tid[k*TIDW +: TIDW] = TIDW'(out_sub) * TIDW'(LANES) + TIDW'(k);
    end
endmodule

// File: rtl/mt_lane_pipe_chk.sv
// Property checker for mt_lane_pipe, attached by bind. Keeps its own shadow
// of issue valid bits and of the expected thread index sequence.
module mt_lane_pipe_chk #(
    parameter int LANES = 8,
    parameter int SUBS  = 4,
    parameter int DEPTH = 8,
    parameter int WARPW = 5,
    localparam int TIDW = $clog2(LANES * SUBS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  iss_valid,
    input logic                  res_valid,
    input logic [LANES*TIDW-1:0] res_tid,
    input logic                  done
);
    logic [DEPTH-1:0] shv;
    logic [TIDW-1:0]  nxt_tid0;

    // shadow of issue valid bits, DEPTH clocks deep
    always_ff @(posedge clk) begin
        if (!rst_n) shv <= '0;
        else        shv <= {shv[DEPTH-2:0], iss_valid};
    end

    // thread index lane 0 must show on the next valid row
    always_ff @(posedge clk) begin
        if (!rst_n)
            nxt_tid0 <= '0;
        else if (res_valid)
            nxt_tid0 <= (res_tid[TIDW-1:0] == TIDW'((SUBS - 1) * LANES))
                        ? '0 : res_tid[TIDW-1:0] + TIDW'(LANES);
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == shv[DEPTH-1]);

    // R9
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_valid && res_tid[TIDW-1:0] == TIDW'((SUBS - 1) * LANES)));

    // R8
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !done);

    // R4
    tid_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_tid[TIDW-1:0] == nxt_tid0);

    for (genvar k = 1; k < LANES; k++) begin : g_lane_chk
        // R4
        tid_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |-> res_tid[k*TIDW +: TIDW] == res_tid[TIDW-1:0] + TIDW'(k));
    end
endmodule

bind mt_lane_pipe mt_lane_pipe_chk #(
    .LANES (LANES),
    .SUBS  (SUBS),
    .DEPTH (DEPTH),
    .WARPW (WARPW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .res_valid (res_valid),
    .res_tid   (res_tid),
    .done      (done)
);

// File: tb/test_mt_lane_pipe.sv
// Self-checking bench: directed and seeded random warps against a ring of
// expected rows computed from the requirements.
module test_mt_lane_pipe;
    import lanepipe_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TIDW = $clog2(LANES * SUBS);
    localparam int ROWW = LANES * DW;
    localparam int RING = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  iss_valid = 1'b0;
    logic [WARPW-1:0]      iss_warp = '0;
    logic [1:0]            iss_op = '0;
    logic [ROWW-1:0]       iss_a = '0, iss_b = '0, iss_c = '0;
    logic                  res_valid;
    logic [WARPW-1:0]      res_warp;
    logic [LANES*TIDW-1:0] res_tid;
    logic [ROWW-1:0]       res_data;
    logic                  done;
    logic [WARPW-1:0]      done_warp;

    mt_lane_pipe i_mt_lane_pipe (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_warp(iss_warp),
        .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b), .iss_c(iss_c),
        .res_valid(res_valid), .res_warp(res_warp), .res_tid(res_tid),
        .res_data(res_data), .done(done), .done_warp(done_warp)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    int bsub = 0;
    logic post_rst = 1'b1;

    logic             rv [RING];
    logic [WARPW-1:0] rw [RING];
    logic [1:0]       rs [RING];
    logic [1:0]       ro [RING];
    logic             rf [RING];
    logic [ROWW-1:0]  rd [RING];

    function automatic logic [DW-1:0] exp_lane(logic [1:0] op, logic [DW-1:0] a,
                                               logic [DW-1:0] b, logic [DW-1:0] c);
        logic [2*DW-1:0] prod;
        prod = a * b;
        case (op)
            2'b01:   return a + b;
            2'b10:   return prod[DW-1:0] + c;
            default: return a;
        endcase
    endfunction

    function automatic logic [ROWW-1:0] rand_row();
        logic [ROWW-1:0] r;
        for (int k = 0; k < LANES; k++) r[k*DW +: DW] = DW'($urandom());
        return r;
    endfunction

    task automatic miss(string tag, string what, logic [63:0] act, logic [63:0] exp);
        nfail++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    endtask

    // compare outputs with the row issued DEPTH steps earlier
    task automatic check_out();
        int idx;
        string dtag;
        idx = (cyc + RING - DEPTH) % RING;
        if (!rv[idx]) begin
            nvec++;
            if (res_valid !== 1'b0 || done !== 1'b0)
                miss("R8", "bubble valid/done", {res_valid, done}, 0);
            return;
        end
        nvec++;
        if (res_valid !== 1'b1) miss("R2", "res_valid", res_valid, 1);
        nvec++;
        if (res_warp !== rw[idx]) miss("R3", "res_warp", res_warp, rw[idx]);
        dtag = (ro[idx] == 2'b01) ? "R6" : (ro[idx] == 2'b10) ? "R7" : "R5";
        for (int k = 0; k < LANES; k++) begin
            logic [TIDW-1:0] et;
            et = TIDW'(rs[idx] * LANES + k);
            nvec++;
            if (res_tid[k*TIDW +: TIDW] !== et)
                miss(rf[idx] ? "R1" : "R4", "res_tid", res_tid[k*TIDW +: TIDW], et);
            nvec++;
            if (res_data[k*DW +: DW] !== rd[idx][k*DW +: DW])
                miss(dtag, "res_data", res_data[k*DW +: DW], rd[idx][k*DW +: DW]);
        end
        nvec++;
        if (done !== (rs[idx] == 2'd3)) miss("R9", "done", done, rs[idx] == 2'd3);
        if (rs[idx] == 2'd3) begin
            nvec++;
            if (done_warp !== rw[idx]) miss("R9", "done_warp", done_warp, rw[idx]);
        end
    endtask

    // one clock: check, then drive the next beat and record what it must give
    task automatic step(input logic r, input logic v, input logic [WARPW-1:0] w,
                        input logic [1:0] op, input logic [ROWW-1:0] a,
                        input logic [ROWW-1:0] b, input logic [ROWW-1:0] c);
        int slot;
        @(negedge clk);
        check_out();
        rst_n = r;
        if (!r) begin
            for (int i = 0; i < RING; i++) rv[i] = 1'b0;
            bsub = 0;
            post_rst = 1'b1;
        end
        iss_valid = v && r;
        iss_warp = w; iss_op = op; iss_a = a; iss_b = b; iss_c = c;
        slot = cyc % RING;
        rv[slot] = v && r;
        rw[slot] = w; ro[slot] = op; rs[slot] = 2'(bsub);
        rf[slot] = post_rst;
        for (int k = 0; k < LANES; k++)
            rd[slot][k*DW +: DW] = exp_lane(op, a[k*DW +: DW], b[k*DW +: DW], c[k*DW +: DW]);
        if (v && r) begin
            bsub = (bsub + 1) % SUBS;
            if (bsub == 0) post_rst = 1'b0;
        end
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, '0, 2'b00, '0, '0, '0);
    endtask

    task automatic do_reset(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 2'b00, '0, '0, '0);
    endtask

    // four beats of one warp, with random bubbles at the given odds (percent)
    task automatic warp(logic [WARPW-1:0] w, logic [1:0] op, int bub, bit ones);
        for (int s = 0; s < SUBS; s++) begin
            while (($urandom() % 100) < bub) idle(1);
            if (ones) step(1'b1, 1'b1, w, op, '1, '1, '1);
            else      step(1'b1, 1'b1, w, op, rand_row(), rand_row(), rand_row());
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL R3 watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < RING; i++) rv[i] = 1'b0;
        do_reset(4);
        // R1: quiet outputs straight after reset
        @(negedge clk);
        nvec++;
        if (res_valid !== 1'b0 || done !== 1'b0)
            miss("R1", "outputs after reset", {res_valid, done}, 0);
        // directed: back-to-back warps, one per opcode (R2, R3, R5-R7)
        for (int o = 0; o < 4; o++) warp(WARPW'(o + 3), 2'(o), 0, 1'b0);
        // corner: all-ones operands wrap (R6, R7)
        warp(5'd30, 2'b01, 0, 1'b1);
        warp(5'd31, 2'b10, 0, 1'b1);
        idle(DEPTH + 2);
        // random warps with bubbles between beats (R8, R9)
        for (int n = 0; n < 150; n++)
            warp(WARPW'($urandom()), 2'($urandom()), 30, 1'b0);
        idle(3);
        // reset part way through a warp, then a fresh warp (R1, R4)
        step(1'b1, 1'b1, 5'd9, 2'b01, rand_row(), rand_row(), rand_row());
        step(1'b1, 1'b1, 5'd9, 2'b01, rand_row(), rand_row(), rand_row());
        do_reset(2);
        warp(5'd12, 2'b10, 0, 1'b0);
        warp(5'd13, 2'b00, 20, 1'b0);
        idle(DEPTH + 4);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule